// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder and Decoder

This block is the optical physical layer that sits between a UART and an infrared transceiver. It runs on a single oversampling clock whose rate is the bit rate times the oversampling factor F. The supported bit rates run from 1.2 to 115.2 kbit/s. On the transmit path, each UART bit cell of F clocks is turned into either a short light pulse or darkness. On the receive path, the photodiode line is synchronized and cleaned by a majority filter. Each accepted pulse then becomes one low UART bit cell.

The mode inputs select the oversampling factor. In normal mode the factor is fixed at 16, and the code input has no effect. In low-power receive mode, a three-bit code selects 16, 32, 48, 96 or 192. This lets a narrow pulse of fixed duration be received at lower bit rates. Both data paths are plain bit-level lines. A line carries no valid/ready handshake and cannot exert back-pressure: the UART must present one bit per F clocks, and the output lines are produced at the same rate. The configuration may change only while both paths are idle.

Top module: `irda_sir_phy`

## Requirements
- R1: While reset is asserted and right after it is released, the transmit pulse output is low and the recovered bit output is high.
- R2: The factor F is 16 when cfg_low_power is 0, whatever the value of cfg_ovs. When cfg_low_power is 1, cfg_ovs values 0, 1, 2, 3 and 4 select F = 16, 32, 48, 96 and 192, and values 5 to 7 select 16.
- R3: A sampled 0 on tx_bit_i that begins a bit cell drives tx_pulse_o high from the next clock for exactly 3*F/16 clocks (integer division). A 1 cell leaves tx_pulse_o low.
- R4: Back-to-back 0 cells each produce their own pulse, and the pulse starts are exactly F clocks apart.
- R5: When rx_pulse_i is high on two or more consecutive rising edges, the pulse is detected and rx_bit_o goes low.
- R6: When rx_pulse_i is high on a single rising edge, or between edges, rx_bit_o stays high.
- R7: For a detected pulse, rx_bit_o goes low after the fifth rising edge, counting the first edge that samples the pulse high as the first. It then stays low for exactly F clocks.
- R8: A new pulse detected while rx_bit_o is still low restarts the F-clock low period from that pulse, so rx_bit_o stays low without a gap.
- R9: Within a pulse, a single-sample low dropout is filled by the 3-sample majority filter. The sequence high, high, low, high, high gives one detection and a low period of F clocks.
- R10: With no pulses on rx_pulse_i, rx_bit_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, F times the bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_low_power | input | 1 | 1 selects low-power receive mode |
| cfg_ovs | input | 3 | Oversampling code, used only in low-power mode |
| tx_bit_i | input | 1 | UART transmit bit stream, one bit per F clocks |
| tx_pulse_o | output | 1 | Active-high drive to the infrared emitter |
| rx_pulse_i | input | 1 | Active-high pulse from the infrared detector, asynchronous |
| rx_bit_o | output | 1 | Recovered UART receive bit stream, idles high |

## Verification
A corrupted transmit cell counter shows up on tx_pulse_o within one bit cell: a pulse that is too long, or pulse starts that drift off the F-clock grid. A stuck receive timer or a wrong factor decode shows up on rx_bit_o as a low period of the wrong length. The error is visible F to F+5 clocks after the pulse that started the period. A median filter that lets single samples through, or that splits a dropout into two detections, changes whether rx_bit_o falls at all, or stretches the low period by the dropout offset, on the very next pulse.

// File: rtl/irda_pkg.sv
`timescale 1ns/1ps
package irda_pkg;

  localparam int unsigned CNT_W = 8;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [2:0] {
    OVS_X16  = 3'd0,
    OVS_X32  = 3'd1,
    OVS_X48  = 3'd2,
    OVS_X96  = 3'd3,
    OVS_X192 = 3'd4
  } ovs_code_e;

  // Clocks per bit cell for the selected mode
  function automatic cnt_t factor_of(input logic low_power, input logic [2:0] code);
    cnt_t f;
    f = cnt_t'(16);
    if (low_power) begin
      case (ovs_code_e'(code))
        OVS_X16:  f = cnt_t'(16);
        OVS_X32:  f = cnt_t'(32);
        OVS_X48:  f = cnt_t'(48);
        OVS_X96:  f = cnt_t'(96);
        OVS_X192: f = cnt_t'(192);
        default:  f = cnt_t'(16);
      endcase
    end
    return f;
  endfunction

  // Optical pulse length: three sixteenths of a cell
  function automatic cnt_t pulse_len(input cnt_t f);
    int p;
    p = int'(f) * 3;
    return cnt_t'(p >> 4);
  endfunction

endpackage

// File: rtl/irda_sync.sv
`timescale 1ns/1ps
module irda_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES < 2) begin : g_single
      logic ff;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= 1'b0;
        else        ff <= d;
      end
      assign q = ff;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/irda_median3.sv
`timescale 1ns/1ps
module irda_median3 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [1:0] hist;
  logic       vote;

  // two of three among the current and two previous samples
  assign vote = (d & hist[0]) | (d & hist[1]) | (hist[0] & hist[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      q    <= 1'b0;
    end else begin
      hist <= {hist[0], d};
      q    <= vote;
    end
  end
endmodule

// File: rtl/irda_rx_timer.sv
`timescale 1ns/1ps
module irda_rx_timer
  import irda_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic filt,
  input  cnt_t factor,
  output logic rise,
  output logic rx_bit
);
  logic filt_d;
  logic busy;
  cnt_t left;

  assign rise   = filt & ~filt_d;
  assign rx_bit = ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_d <= 1'b0;
      busy   <= 1'b0;
      left   <= '0;
    end else begin
      filt_d <= filt;
      if (rise) begin
        busy <= 1'b1;
        left <= factor - cnt_t'(1);
      end else if (busy) begin
        if (left == '0) busy <= 1'b0;
        else            left <= left - cnt_t'(1);
      end
    end
  end
endmodule

// File: rtl/irda_tx_enc.sv
`timescale 1ns/1ps
module irda_tx_enc
  import irda_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_bit,
  input  cnt_t factor,
  input  cnt_t width,
  output logic tx_pulse
);
  logic active;
  cnt_t pos;

  assign tx_pulse = active && (pos < width);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pos    <= '0;
    end else if (!active) begin
      if (!tx_bit) begin
        active <= 1'b1;
        pos    <= '0;
      end
    end else if (pos >= factor - cnt_t'(1)) begin
      if (!tx_bit) pos    <= '0;
      else         active <= 1'b0;
    end else begin
      pos <= pos + cnt_t'(1);
    end
  end
endmodule

// File: rtl/irda_sir_phy.sv
`timescale 1ns/1ps
module irda_sir_phy #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_low_power,
  input  logic [2:0] cfg_ovs,
  input  logic       tx_bit_i,
  output logic       tx_pulse_o,
  input  logic       rx_pulse_i,
  output logic       rx_bit_o
);
  import irda_pkg::*;

  cnt_t factor;
  cnt_t width;
  logic rx_sync;
  logic rx_filt;
  logic rx_rise;

  assign factor = factor_of(cfg_low_power, cfg_ovs);
  assign width  = pulse_len(factor);

  irda_tx_enc u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_bit   (tx_bit_i),
    .factor   (factor),
    .width    (width),
    .tx_pulse (tx_pulse_o)
  );

  irda_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rx_pulse_i),
    .q     (rx_sync)
  );

  irda_median3 u_med (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rx_sync),
    .q     (rx_filt)
  );

  irda_rx_timer u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .filt   (rx_filt),
    .factor (factor),
    .rise   (rx_rise),
    .rx_bit (rx_bit_o)
  );
endmodule

// File: rtl/irda_sir_phy_chk.sv
`timescale 1ns/1ps
module irda_sir_phy_chk
  import irda_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_low_power,
  input logic [2:0] cfg_ovs,
  input logic       tx_bit_i,
  input logic       tx_pulse_o,
  input logic       rx_pulse_i,
  input logic       rx_bit_o,
  input logic       rx_rise
);
  cnt_t f_chk;
  cnt_t w_chk;
  logic [9:0] hi_run;
  logic [9:0] since_rise;

  assign f_chk = factor_of(cfg_low_power, cfg_ovs);
  assign w_chk = pulse_len(f_chk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run     <= '0;
      since_rise <= '1;
    end else begin
      hi_run <= tx_pulse_o ? hi_run + 10'd1 : 10'd0;
      if (rx_rise)              since_rise <= '0;
      else if (since_rise != '1) since_rise <= since_rise + 10'd1;
    end
  end

  p_pulse_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_pulse_o) |-> !$past(tx_bit_i));

  p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pulse_o |-> (hi_run < 10'(w_chk)));

  p_fall_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_bit_o) |-> ($past(rx_pulse_i, 4) || $past(rx_pulse_i, 5)));

  p_low_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_bit_o |-> (since_rise < 10'(f_chk)));
endmodule

bind irda_sir_phy irda_sir_phy_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_low_power (cfg_low_power),
  .cfg_ovs       (cfg_ovs),
  .tx_bit_i      (tx_bit_i),
  .tx_pulse_o    (tx_pulse_o),
  .rx_pulse_i    (rx_pulse_i),
  .rx_bit_o      (rx_bit_o),
  .rx_rise       (rx_rise)
);

// File: tb/irda_sir_phy_test.sv
`timescale 1ns/1ps
module irda_sir_phy_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_lp = 1'b0;
  logic [2:0] cfg_ovs = 3'd0;
  logic       tx_bit = 1'b1;
  logic       rx_pulse = 1'b0;
  logic       tx_pulse;
  logic       rx_bit;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int cur_f = 16;
  int cur_w = 3;
  logic prev_bit = 1'b1;
  int prev_off = 0;
  int cell_off = 0;
  logic last_rx;

  always #2 clk = ~clk;

  irda_sir_phy uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_low_power (cfg_lp),
    .cfg_ovs       (cfg_ovs),
    .tx_bit_i      (tx_bit),
    .tx_pulse_o    (tx_pulse),
    .rx_pulse_i    (rx_pulse),
    .rx_bit_o      (rx_bit)
  );

  function automatic int fac(input logic lp, input int code);
    if (!lp) return 16;
    case (code)
      0: return 16;
      1: return 32;
      2: return 48;
      3: return 96;
      4: return 192;
      default: return 16;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: observe at the falling edge, then drive the next inputs
  task automatic step(input logic tb, input logic rb);
    logic exp_tx;
    @(negedge clk);
    exp_tx = (prev_bit == 1'b0) && (prev_off < cur_w);
    chk(tx_pulse === exp_tx, "R3 R4 tx pulse", int'(tx_pulse), int'(exp_tx));
    last_rx = rx_bit;
    tx_bit = tb;
    rx_pulse = rb;
    prev_bit = tb;
    prev_off = cell_off;
  endtask

  task automatic set_cfg(input logic lp, input int code);
    cell_off = 0;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
    cfg_lp = lp;
    cfg_ovs = 3'(code);
    cur_f = fac(lp, code);
    cur_w = cur_f * 3 / 16;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
  endtask

  task automatic tx_frame(input logic [7:0] data);
    logic [9:0] bits;
    bits = {1'b1, data, 1'b0};
    for (int b = 0; b < 10; b++) begin
      for (int off = 0; off < cur_f; off++) begin
        cell_off = off;
        step(bits[b], 1'b0);
        chk(last_rx === 1'b1, "R10 rx idle", int'(last_rx), 1);
      end
    end
    cell_off = 0;
  endtask

  task automatic rx_shot(input logic [15:0] pat, input int plen, input int win,
                         output int first_low, output int last_low, output int nlow);
    first_low = -1;
    last_low = -1;
    nlow = 0;
    cell_off = 0;
    for (int k = 0; k < win; k++) begin
      step(1'b1, (k < plen) ? pat[k] : 1'b0);
      if (k > 0 && last_rx === 1'b0) begin
        nlow++;
        if (first_low < 0) first_low = k;
        last_low = k;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic cl_lp [8];
    int   cl_code [8];
    int fl, ll, nl, w;
    cl_lp   = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
    cl_code = '{0, 3, 0, 1, 2, 3, 4, 6};
    void'($urandom(32'd2024));

    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(tx_pulse === 1'b0, "R1 tx in reset", int'(tx_pulse), 0);
      chk(rx_bit === 1'b1, "R1 rx in reset", int'(rx_bit), 1);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_pulse === 1'b0, "R1 tx after reset", int'(tx_pulse), 0);
    chk(rx_bit === 1'b1, "R1 rx after reset", int'(rx_bit), 1);

    for (int c = 0; c < 8; c++) begin
      // R2: factor chosen per mode and code, seen through pulse and bit lengths
      set_cfg(cl_lp[c], cl_code[c]);

      tx_frame(8'h00);                 // R4 runs of zero cells
      tx_frame(8'hFF);                 // R3 ones make no pulse
      tx_frame(8'($urandom()));
      tx_frame(8'($urandom()));

      w = 2 + int'($urandom() % 4);
      rx_shot(16'((1 << w) - 1), w, cur_f + 20, fl, ll, nl);
      chk(fl == 5, "R5 R7 first low", fl, 5);
      chk(nl == cur_f, "R2 R7 low length", nl, cur_f);
      chk(ll == 4 + cur_f, "R7 last low", ll, 4 + cur_f);

      rx_shot(16'h0001, 1, cur_f + 20, fl, ll, nl);
      chk(nl == 0, "R6 single sample ignored", nl, 0);

      rx_shot(16'b11011, 5, cur_f + 20, fl, ll, nl);
      chk(nl == cur_f, "R9 dropout filled", nl, cur_f);
      chk(ll == 4 + cur_f, "R9 last low", ll, 4 + cur_f);

      rx_shot(16'b0000_0111_0000_0111, 11, cur_f + 20, fl, ll, nl);
      chk(fl == 5, "R8 first low", fl, 5);
      chk(ll == 12 + cur_f, "R8 restarted end", ll, 12 + cur_f);
      chk(nl == 8 + cur_f, "R8 no gap", nl, 8 + cur_f);
    end

    // R6: pulse placed between two rising edges is never sampled
    @(negedge clk);
    #0.5 rx_pulse = 1'b1;
    #1.0 rx_pulse = 1'b0;
    for (int i = 0; i < 12; i++) begin
      step(1'b1, 1'b0);
      chk(last_rx === 1'b1, "R6 sub-clock pulse", int'(last_rx), 1);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule